// File: doc/BRIEF.md
# Quadrature Encoder Emulator and Position Decoder

This block holds two independent halves that are normally used back to back in a motor-drive test setup. The emulator half takes a per-unit rotor angle word, where full scale is one mechanical revolution, and a rotation-sense flag. It drives a pair of quadrature channels, A and B, in the way an incremental encoder with a fixed number of slits per turn would. The slit count comes from how many upper bits of the angle word are decoded. With the defaults there are 8 slits, which gives 32 quadrature events per turn.

The decoder half takes a pair of quadrature channels from outside and passes each through a two-flop synchronizer. It compares the synchronized pair with the pair held from the previous clock, and moves a position counter one step up or down. At the end of a turn the counter wraps to zero or to the full-turn value. It reports the rebuilt angle in the same per-unit scale as the input word, along with the sense of the last valid step and a one-cycle flag for an illegal jump.

Top module: `qenc_top`

## Requirements
- R1: While `rst_n` is low and after it is released with no stimulus, `enc_a`/`enc_b` are 0/0, `turn_pos` is 0, `move_fwd` is 0 and `step_err` is 0.
- R2: With `rotor_ccw` = 0, the event phase held in bits [12:11] of `rotor_pos` (defaults) maps to {A,B} as: 0 to 10, 1 to 11, 2 to 01, 3 to 00. The outputs show the new code one clock after the input changes, and other bits of `rotor_pos` have no effect on the code.
- R3: With `rotor_ccw` = 1, the same phase bits map to {A,B} as: 0 to 01, 1 to 11, 2 to 10, 3 to 00.
- R4: The emulator changes at most one of `enc_a`/`enc_b` per clock. When the target code differs from the present one in both bits, A flips first and B flips on the following clock.
- R5: The decoder counts +1 for each of these transitions of {A,B} (previous to current): 10 to 00, 11 to 10, 01 to 11, 00 to 01. The new count appears on `turn_pos` after the third rising edge following the change on the sense inputs.
- R6: The decoder counts −1 for each of these transitions: 01 to 00, 11 to 01, 10 to 11, 00 to 10. The timing is the same as in R5.
- R7: When both sense bits change at once, the count and `move_fwd` keep their values and `step_err` is high for exactly one cycle.
- R8: A +1 step from the top count (31 with the defaults) gives 0.
- R9: A −1 step from count 0 gives the top count (31 with the defaults).
- R10: `move_fwd` becomes 1 after a +1 step and 0 after a −1 step, and holds its value otherwise.
- R11: `turn_pos` carries the count in its upper bits [15:11] (defaults), and its lower bits are zero.
- R12: When the emulator outputs are looped into the decoder and the angle is swept through one full turn, the count ends where it started. This holds for a sweep upward in angle and for one downward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rotor_pos | input | POS_W | Per-unit mechanical angle, full scale is one turn |
| rotor_ccw | input | 1 | Rotation sense for the emulator: 0 selects the R2 table, 1 the R3 table |
| enc_a | output | 1 | Emulated channel A |
| enc_b | output | 1 | Emulated channel B |
| sense_a | input | 1 | Channel A into the decoder (asynchronous) |
| sense_b | input | 1 | Channel B into the decoder (asynchronous) |
| turn_pos | output | POS_W | Rebuilt per-unit angle |
| move_fwd | output | 1 | Sense of the last valid step, 1 for +1 |
| step_err | output | 1 | One-cycle pulse on a two-bit jump |

## Verification
The checks assume that the sense inputs settle between clock edges and are at 00 when reset is released, so the first comparison after reset sees no movement. They also assume that a two-bit jump is never followed on the next clock by a second one, because back-to-back errors would hold `step_err` high over adjacent cycles. The bench drives the sense pins at falling edges, holds each value for at least three clocks, and starts from 00. In loopback mode it moves the angle by only one quadrature event per clock. That keeps every emitted change a single-bit one, so the decoder never sees an illegal jump during the sweeps.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_REV  = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // Channel code {A,B} for a quadrature phase (R2, R3).
  function automatic logic [1:0] emit_code(input logic ccw, input logic [1:0] phase);
    logic [1:0] code;
    if (!ccw) begin
      case (phase)
        2'd0:    code = 2'b10;
        2'd1:    code = 2'b11;
        2'd2:    code = 2'b01;
        default: code = 2'b00;
      endcase
    end else begin
      case (phase)
        2'd0:    code = 2'b01;
        2'd1:    code = 2'b11;
        2'd2:    code = 2'b10;
        default: code = 2'b00;
      endcase
    end
    return code;
  endfunction

  // Movement implied by a previous/current channel pair (R5, R6, R7).
  function automatic step_e classify(input logic [1:0] prev, input logic [1:0] cur);
    step_e s;
    if (prev == cur)                s = STEP_NONE;
    else if ((prev ^ cur) == 2'b11) s = STEP_BAD;
    else begin
      case ({prev, cur})
        4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: s = STEP_FWD;
        default:                                s = STEP_REV;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/qenc_emit.sv
module qenc_emit #(
  parameter int POS_W     = 16,
  parameter int SLIT_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos,
  input  logic             ccw,
  output logic [1:0]       ab
);
  import qenc_pkg::*;

  localparam int EV_W  = SLIT_BITS + 2;
  localparam int PH_LO = POS_W - EV_W;

  logic [1:0] ab_q, ab_d, want;
  logic [POS_W-3:0] pos_unused;

  assign pos_unused = {pos[POS_W-1:PH_LO+2], pos[PH_LO-1:0]};

  always_comb begin
    want = emit_code(ccw, pos[PH_LO +: 2]);
    if ((want ^ ab_q) == 2'b11) ab_d = ab_q ^ 2'b10;
    else                        ab_d = want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ab_q <= 2'b00;
    else        ab_q <= ab_d;
  end

  assign ab = ab_q;
endmodule

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qenc_track.sv
module qenc_track #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ab,
  output logic [CNT_W-1:0] cnt,
  output logic             fwd,
  output logic             err
);
  import qenc_pkg::*;

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [1:0]       prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fwd_q, fwd_d, err_q, err_d;
  step_e            step;

  always_comb begin
    step  = classify(prev_q, ab);
    cnt_d = cnt_q;
    fwd_d = fwd_q;
    err_d = 1'b0;
    case (step)
      STEP_FWD: begin
        cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
        fwd_d = 1'b1;
      end
      STEP_REV: begin
        cnt_d = (cnt_q == '0) ? TOP : cnt_q - 1'b1;
        fwd_d = 1'b0;
      end
      STEP_BAD: err_d = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'b00;
      cnt_q  <= '0;
      fwd_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= ab;
      cnt_q  <= cnt_d;
      fwd_q  <= fwd_d;
      err_q  <= err_d;
    end
  end

  assign cnt = cnt_q;
  assign fwd = fwd_q;
  assign err = err_q;
endmodule

// File: rtl/qenc_top.sv
module qenc_top #(
  parameter int POS_W     = 16,
  parameter int SLIT_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] rotor_pos,
  input  logic             rotor_ccw,
  output logic             enc_a,
  output logic             enc_b,
  input  logic             sense_a,
  input  logic             sense_b,
  output logic [POS_W-1:0] turn_pos,
  output logic             move_fwd,
  output logic             step_err
);
  localparam int CNT_W = SLIT_BITS + 2;
  localparam int LSB_W = POS_W - CNT_W;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [1:0]       emit_ab, sense_sync;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  qenc_emit #(.POS_W(POS_W), .SLIT_BITS(SLIT_BITS)) u_emit (
    .clk(clk), .rst_n(rst_int_n), .pos(rotor_pos), .ccw(rotor_ccw), .ab(emit_ab)
  );

  qenc_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d({sense_a, sense_b}), .q(sense_sync)
  );

  qenc_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_int_n), .ab(sense_sync),
    .cnt(cnt), .fwd(move_fwd), .err(step_err)
  );

  assign enc_a    = emit_ab[1];
  assign enc_b    = emit_ab[0];
  assign turn_pos = {cnt, {LSB_W{1'b0}}};
endmodule

// File: rtl/qenc_chk.sv
module qenc_chk #(
  parameter int POS_W     = 16,
  parameter int SLIT_BITS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enc_a,
  input logic             enc_b,
  input logic [POS_W-1:0] turn_pos,
  input logic             move_fwd,
  input logic             step_err
);
  localparam int CNT_W = SLIT_BITS + 2;
  localparam logic [POS_W-1:0] UNIT = POS_W'(1) << (POS_W - CNT_W);

  // R4
  a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({enc_a, enc_b} ^ $past({enc_a, enc_b})) <= 1);

  // R5 R6 R8 R9: any movement is one unit, modulo one turn
  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(turn_pos) |-> (turn_pos == $past(turn_pos) + UNIT) ||
                           (turn_pos == $past(turn_pos) - UNIT));

  // R10
  a_r10_up_sets_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_pos == $past(turn_pos) + UNIT) |-> move_fwd);

  // R7
  a_r7_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |-> $stable(turn_pos));

  // R7
  a_r7_hold_sense: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |-> $stable(move_fwd));

  // R11
  a_r11_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    turn_pos[POS_W-CNT_W-1:0] == '0);
endmodule

bind qenc_top qenc_chk #(.POS_W(POS_W), .SLIT_BITS(SLIT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
  .turn_pos(turn_pos), .move_fwd(move_fwd), .step_err(step_err)
);

// File: tb/sim_qenc_top.sv
`timescale 1ns/1ps
module sim_qenc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] rotor_pos;
  logic        rotor_ccw;
  logic        enc_a, enc_b;
  logic        drv_a, drv_b, loop_en;
  logic        sense_a, sense_b;
  logic [15:0] turn_pos;
  logic        move_fwd, step_err;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  assign sense_a = loop_en ? enc_a : drv_a;
  assign sense_b = loop_en ? enc_b : drv_b;

  qenc_top u0 (
    .clk(clk), .rst_n(rst_n), .rotor_pos(rotor_pos), .rotor_ccw(rotor_ccw),
    .enc_a(enc_a), .enc_b(enc_b), .sense_a(sense_a), .sense_b(sense_b),
    .turn_pos(turn_pos), .move_fwd(move_fwd), .step_err(step_err)
  );

  // {req[3:0], ab[1:0], count[4:0], move_fwd, step_err}
  localparam logic [12:0] VEC [12] = '{
    {4'd5, 2'b01, 5'd1,  1'b1, 1'b0},  // R5
    {4'd5, 2'b11, 5'd2,  1'b1, 1'b0},  // R5
    {4'd5, 2'b10, 5'd3,  1'b1, 1'b0},  // R5
    {4'd5, 2'b00, 5'd4,  1'b1, 1'b0},  // R5
    {4'd6, 2'b10, 5'd3,  1'b0, 1'b0},  // R6
    {4'd6, 2'b11, 5'd2,  1'b0, 1'b0},  // R6
    {4'd6, 2'b01, 5'd1,  1'b0, 1'b0},  // R6
    {4'd6, 2'b00, 5'd0,  1'b0, 1'b0},  // R6
    {4'd9, 2'b10, 5'd31, 1'b0, 1'b0},  // R9 wrap down
    {4'd8, 2'b00, 5'd0,  1'b1, 1'b0},  // R8 wrap up
    {4'd7, 2'b11, 5'd0,  1'b1, 1'b1},  // R7 double change
    {4'd7, 2'b00, 5'd0,  1'b1, 1'b1}   // R7 double change back
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic emit_step(input logic ccw, input logic [1:0] ph, input logic [1:0] exp,
                           input string req);
    rotor_ccw = ccw;
    rotor_pos = {3'b000, ph, 11'h123};
    @(negedge clk);
    chk(req, {30'd0, enc_a, enc_b}, {30'd0, exp});
  endtask

  task automatic sweep(input int start, input int dir, input int n);
    for (int k = 1; k <= n; k++) begin
      rotor_pos = 16'(((start + dir * k) & 31) << 11);
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rotor_pos = '0; rotor_ccw = 1'b0;
    drv_a = 1'b0; drv_b = 1'b0; loop_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 enc in reset", {30'd0, enc_a, enc_b}, 32'd0);
    chk("R1 pos in reset", {16'd0, turn_pos}, 32'd0);
    rst_n = 1'b1;
    rotor_pos = 16'h1800;  // phase 3: code 00 in both tables
    repeat (4) @(negedge clk);
    chk("R1 enc after release", {30'd0, enc_a, enc_b}, 32'd0);
    chk("R1 pos after release", {16'd0, turn_pos}, 32'd0);
    chk("R1 sense", {31'd0, move_fwd}, 32'd0);
    chk("R1 err", {31'd0, step_err}, 32'd0);

    // decoder table walk (R5 R6 R7 R8 R9 R10 R11)
    foreach (VEC[i]) begin
      logic [12:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d vec%0d", v[12:9], i);
      drv_a = v[8]; drv_b = v[7];
      repeat (3) @(negedge clk);
      chk({tg, " R11 pos"}, {16'd0, turn_pos}, {16'd0, v[6:2], 11'd0});
      chk({tg, " R10 sense"}, {31'd0, move_fwd}, {31'd0, v[1]});
      chk({tg, " err"}, {31'd0, step_err}, {31'd0, v[0]});
      if (v[0]) begin
        @(negedge clk);
        chk("R7 err one cycle", {31'd0, step_err}, 32'd0);
      end
    end

    // emulator tables
    emit_step(1'b0, 2'd0, 2'b10, "R2 ph0");
    emit_step(1'b0, 2'd1, 2'b11, "R2 ph1");
    emit_step(1'b0, 2'd2, 2'b01, "R2 ph2");
    emit_step(1'b0, 2'd3, 2'b00, "R2 ph3");
    emit_step(1'b1, 2'd0, 2'b01, "R3 ph0");
    emit_step(1'b1, 2'd1, 2'b11, "R3 ph1");
    emit_step(1'b1, 2'd2, 2'b10, "R3 ph2");
    emit_step(1'b1, 2'd3, 2'b00, "R3 ph3");
    // R4: 00 -> 11 goes through 10
    emit_step(1'b0, 2'd1, 2'b10, "R4 first A");
    @(negedge clk);
    chk("R4 then B", {30'd0, enc_a, enc_b}, 32'd3);
    // back to 00 through 01, ccw phase 3 at event 3
    rotor_ccw = 1'b1;
    rotor_pos = 16'(3 << 11);
    repeat (3) @(negedge clk);
    chk("R4 settle", {30'd0, enc_a, enc_b}, 32'd0);

    // R12 loopback sweeps, decoder count is 0, inputs 00
    loop_en = 1'b1;
    sweep(3, 1, 16);
    chk("R12 half turn up", {16'd0, turn_pos}, 32'h8000);
    sweep(19, 1, 16);
    chk("R12 full turn up", {16'd0, turn_pos}, 32'd0);
    sweep(35, -1, 32);
    chk("R12 full turn down", {16'd0, turn_pos}, 32'd0);
    chk("R12 no error", {31'd0, step_err}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule